// File: doc/BRIEF.md
# Serial Channel Register and Interrupt Unit

This block is the byte-wide register file of a single asynchronous serial channel that follows the familiar 16550 register layout and adds an extended mode. A host reaches eight byte offsets through a small synchronous bus. Through them it sets the character format, the modem-control outputs and the baud divisor, and it reads line and modem status. When a bit in the line control register is set, three of the offsets switch to a second bank that holds the divisor and the extended-feature register.

The unit takes status from the receive FIFO, which lives outside this block: the fill level, the byte at the head, its error flags, a receive time-out flag and an overrun pulse. It also takes the transmitter-empty flag and four modem input levels. From these it keeps the sticky status bits and raises a single prioritised interrupt. The serializer, the baud generator and the FIFO storage sit around this unit. They are driven by its outputs: the character format, the break and modem-control levels, the 16-bit divisor, the FIFO enable, the extended-mode flag, and push and pop strobes for the holding register.

Top module: `serchan_regs`

## Requirements
- R1: After reset, line control, interrupt enable, modem control, scratch, divisor and extended-feature registers read 0. The interrupt status reads 0x01, `irq` is 0, and `dtr` and `rts` are 0.
- R2: Offset 3 (line control) reads back as written. Bits 1:0 drive `word_len` (0 to 3 for 5 to 8 data bits). Bit 2 drives `two_stop`, bit 3 `parity_en`, bit 4 `parity_even` and bit 6 `break_on`. Bit 7 is the bank-select bit.
- R3: While line-control bit 7 is 1, offsets 0, 1 and 2 read and write the divisor low byte, the divisor high byte and the extended-feature register. Such writes reach neither the transmitter nor the interrupt enable nor the FIFO control. `divisor` equals {high, low}, and `enhanced_en` is extended-feature bit 4.
- R4: With bit 7 clear, a write to offset 0 pulses `tx_push` for one cycle with `tx_byte` equal to the written byte. A read of offset 0 returns `rx_data` and pulses `rx_pop` only when `rx_level` is non-zero.
- R5: Offset 4 (modem control) bit 0 drives `dtr` and bit 1 drives `rts`. Bits 4:0 read back.
- R6: A write to offset 2 with bit 7 clear sets the FIFO enable from bit 0 and the receive trigger from bits 7:6 (0 to 3 give 16, 32, 64 and 112 entries). With the FIFO enabled, receive data is available when `rx_level` is at least the trigger. With it disabled, data is available when `rx_level` is at least 1. Interrupt-status bits 7:6 both read as the FIFO enable.
- R7: Offset 5 (line status) gives bit 0 data ready (`rx_level` non-zero), bit 1 overrun, bit 2 parity error and bit 3 framing error. The two error bits are the head-byte flags, qualified by data ready. Bit 5 is `tx_empty`, bit 7 is the OR of bits 2 and 3, and bits 4 and 6 read 0.
- R8: An `rx_overrun` pulse sets line-status bit 1, which stays set until line status is read. A pulse in the same cycle as the read wins.
- R9: Offset 6 (modem status) bits 4 to 7 are the sampled CTS, DSR, RI and DCD levels, one cycle behind the pins. Bits 0, 1 and 3 are set when CTS, DSR or DCD changes, and a read of offset 6 clears them. A change in the same cycle as the read wins. Bit 2 reads 0, and RI changes set no flag.
- R10: The interrupt status (offset 2 read, bit 7 clear) reports the highest-priority enabled source in this order: 0x06 line error, 0x04 data available, 0x0C receive time-out (time-out flag with data present), 0x02 transmitter empty, 0x00 modem change. It reports 0x01 when nothing is pending.
- R11: The transmitter-empty condition is set when `tx_empty` rises, or when interrupt-enable bit 1 goes from 0 to 1 while `tx_empty` is 1. It is cleared by a write to offset 0 with bit 7 clear, or by an interrupt-status read that reports 0x02. A set in the same cycle as a clear wins.
- R12: Interrupt-enable bits 0 to 3 gate receive data (and time-out), transmitter empty, line error and modem change. `irq` is 1 exactly when the interrupt status is not 0x01.
- R13: Offset 7 is a scratch byte that reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on this edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rx_level | input | 8 | Receive FIFO fill level, 0 to 128 |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_parity_err | input | 1 | Parity error on the head byte |
| rx_frame_err | input | 1 | Framing error on the head byte |
| rx_overrun | input | 1 | One-cycle pulse: a byte was lost |
| rx_timeout | input | 1 | Receive idle time-out flag |
| tx_empty | input | 1 | Transmit holding space is empty |
| cts_in | input | 1 | Clear-to-send level |
| dsr_in | input | 1 | Data-set-ready level |
| ri_in | input | 1 | Ring indicator level |
| dcd_in | input | 1 | Carrier-detect level |
| tx_push | output | 1 | Push `tx_byte` to the transmit FIFO |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop the receive FIFO head |
| word_len | output | 2 | Data-bit code (5 to 8 bits) |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity |
| break_on | output | 1 | Force line break |
| divisor | output | 16 | Baud divisor {high, low} |
| fifo_en | output | 1 | FIFOs enabled |
| enhanced_en | output | 1 | Extended mode enabled |
| dtr | output | 1 | Data-terminal-ready output |
| rts | output | 1 | Request-to-send output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is several interrupt sources pending at once. It needs a line error, data at or above the trigger, a time-out, a transmitter-empty edge and a modem delta together. Only then can the priority order and the clear-on-read side effects be seen one layer at a time. The directed phase builds this stack on purpose by holding input levels and toggling `tx_empty` and a modem pin. It then peels the stack off with successive interrupt-status and modem-status reads. A random phase follows that drives bus operations and pin levels every cycle. A behavioural model checks the read data and every output on each clock.

// File: rtl/sercfg_pkg.sv
// Shared constants for the serial channel register unit.
// Assumes an 8-offset byte register map and a 6-bit interrupt code field.
package sercfg_pkg;

    // Register offsets
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IEN   = 3'd1;
    localparam logic [2:0] OFS_FCTL  = 3'd2;
    localparam logic [2:0] OFS_LCTL  = 3'd3;
    localparam logic [2:0] OFS_MCTL  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;
    localparam logic [2:0] OFS_SCR   = 3'd7;

    // Interrupt identification codes
    typedef enum logic [5:0] {
        ID_MODEM   = 6'h00,
        ID_NONE    = 6'h01,
        ID_THRE    = 6'h02,
        ID_RXDATA  = 6'h04,
        ID_LINE    = 6'h06,
        ID_TIMEOUT = 6'h0C
    } int_id_e;

    // Receive trigger threshold for a trigger select code and FIFO depth
    function automatic int trig_of(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return depth / 8;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/serchan_cfg_regs.sv
// Writable configuration registers: line control, interrupt enable,
// modem control, scratch, divisor bytes, extended-feature byte and
// FIFO control. Line-control bit 7 redirects offsets 0..2 to the
// second bank. Assumes at most one write strobe per cycle.
module serchan_cfg_regs
    import sercfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] lcr_q,
    output logic [3:0] ier_q,
    output logic [4:0] mcr_q,
    output logic [7:0] scr_q,
    output logic [7:0] dll_q,
    output logic [7:0] dlm_q,
    output logic [7:0] efr_q,
    output logic       fifo_on_q,
    output logic [1:0] trig_sel_q,
    output logic       thr_wr,
    output logic       ier_thre_on
);

    logic bank2;
    logic wr_lcr, wr_ier, wr_mcr, wr_scr, wr_dll, wr_dlm, wr_efr, wr_fcr;

    // Decode write strobes from offset and bank select
    always_comb begin
        bank2  = lcr_q[7];
        thr_wr = wr_en && (addr == OFS_DATA) && !bank2;
        wr_dll = wr_en && (addr == OFS_DATA) &&  bank2;
        wr_ier = wr_en && (addr == OFS_IEN)  && !bank2;
        wr_dlm = wr_en && (addr == OFS_IEN)  &&  bank2;
        wr_fcr = wr_en && (addr == OFS_FCTL) && !bank2;
        wr_efr = wr_en && (addr == OFS_FCTL) &&  bank2;
        wr_lcr = wr_en && (addr == OFS_LCTL);
        wr_mcr = wr_en && (addr == OFS_MCTL);
        wr_scr = wr_en && (addr == OFS_SCR);
        ier_thre_on = wr_ier && wdata[1] && !ier_q[1];
    end

    // Register the written bytes, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q      <= '0;
            ier_q      <= '0;
            mcr_q      <= '0;
            scr_q      <= '0;
            dll_q      <= '0;
            dlm_q      <= '0;
            efr_q      <= '0;
            fifo_on_q  <= 1'b0;
            trig_sel_q <= 2'd0;
        end else begin
            if (wr_lcr) lcr_q <= wdata;
            if (wr_ier) ier_q <= wdata[3:0];
            if (wr_mcr) mcr_q <= wdata[4:0];
            if (wr_scr) scr_q <= wdata;
            if (wr_dll) dll_q <= wdata;
            if (wr_dlm) dlm_q <= wdata;
            if (wr_efr) efr_q <= wdata;
            if (wr_fcr) begin
                fifo_on_q  <= wdata[0];
                trig_sel_q <= wdata[7:6];
            end
        end
    end

endmodule

// File: rtl/serchan_line_status.sv
// Line status composition: data ready, qualified head-byte errors,
// a sticky overrun flag and transmitter-empty level.
// Assumes rx_overrun is a one-cycle pulse from the receive FIFO.
module serchan_line_status #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_parity_err,
    input  logic             rx_frame_err,
    input  logic             rx_overrun,
    input  logic             tx_empty,
    input  logic             lsr_read,
    output logic [7:0]       lsr,
    output logic             line_err,
    output logic             data_ready,
    output logic             ovr_q
);

    logic perr, ferr;

    // Sticky overrun: a new pulse wins over the clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)          ovr_q <= 1'b0;
        else if (rx_overrun) ovr_q <= 1'b1;
        else if (lsr_read)   ovr_q <= 1'b0;
    end

    // Assemble the status byte and the line-error condition
    always_comb begin
        data_ready = (rx_level != '0);
        perr       = data_ready && rx_parity_err;
        ferr       = data_ready && rx_frame_err;
        lsr        = {perr || ferr, 1'b0, tx_empty, 1'b0, ferr, perr, ovr_q, data_ready};
        line_err   = ovr_q || perr || ferr;
    end

endmodule

// File: rtl/serchan_modem_status.sv
// Modem input sampling with per-pin change flags. DELTA_MASK selects
// which pins report changes; reading the status clears the flags.
// Assumes the pins are already synchronous to clk.
module serchan_modem_status #(
    parameter int          NPIN       = 4,
    parameter logic [3:0]  DELTA_MASK = 4'b1011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins,
    input  logic            msr_read,
    output logic [NPIN-1:0] pin_q,
    output logic [NPIN-1:0] delta_q,
    output logic            any_delta
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        // Sample the pin level one cycle late
        always_ff @(posedge clk) begin
            if (!rst_n) pin_q[i] <= 1'b0;
            else        pin_q[i] <= pins[i];
        end

        if (DELTA_MASK[i]) begin : g_delta
            // Change flag: a new change wins over the clearing read
            always_ff @(posedge clk) begin
                if (!rst_n)                  delta_q[i] <= 1'b0;
                else if (pins[i] != pin_q[i]) delta_q[i] <= 1'b1;
                else if (msr_read)           delta_q[i] <= 1'b0;
            end
        end else begin : g_nodelta
            assign delta_q[i] = 1'b0;
        end
    end

    assign any_delta = |delta_q;

endmodule

// File: rtl/serchan_int_ctrl.sv
// Interrupt pending logic and priority encoder. Keeps the
// transmitter-empty pending flag and selects the identification code.
// Assumes tx_empty is a level from the transmit FIFO.
module serchan_int_ctrl
    import sercfg_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier,
    input  logic             line_err,
    input  logic             data_ready,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             fifo_on,
    input  logic [1:0]       trig_sel,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic             thr_wr,
    input  logic             ier_thre_on,
    input  logic             isr_read,
    input  logic             modem_delta,
    output logic [5:0]       id_code,
    output logic             thre_q,
    output logic             irq
);

    logic             tx_prev;
    logic [LVL_W-1:0] trig_lvl;
    logic             rx_avail;
    logic             thre_set;
    int_id_e          id;

    // Previous transmitter-empty level for edge detection
    always_ff @(posedge clk) tx_prev <= tx_empty;

    // Receive availability against the selected trigger
    always_comb begin
        trig_lvl = LVL_W'(trig_of(trig_sel, FIFO_DEPTH));
        rx_avail = fifo_on ? (rx_level >= trig_lvl) : data_ready;
        thre_set = (tx_empty && !tx_prev) || (ier_thre_on && tx_empty);
    end

    // Transmitter-empty pending flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                                  thre_q <= 1'b0;
        else if (thre_set)                           thre_q <= 1'b1;
        else if (thr_wr || (isr_read && id == ID_THRE)) thre_q <= 1'b0;
    end

    // Priority encoder over enabled sources
    always_comb begin
        if (ier[2] && line_err)                 id = ID_LINE;
        else if (ier[0] && rx_avail)            id = ID_RXDATA;
        else if (ier[0] && rx_timeout && data_ready) id = ID_TIMEOUT;
        else if (ier[1] && thre_q)              id = ID_THRE;
        else if (ier[3] && modem_delta)         id = ID_MODEM;
        else                                    id = ID_NONE;
        id_code = id;
        irq     = (id != ID_NONE);
    end

endmodule

// File: rtl/serchan_regs.sv
// Top of the serial channel register unit: bus decode, read mux and
// the wiring of configuration, line status, modem status and interrupt
// logic. Reads are combinational; read side effects take place on the
// clock edge where bus_rd is high. Assumes bus_wr and bus_rd are not
// both high in one cycle.
module serchan_regs
    import sercfg_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [7:0]       rx_data,
    input  logic             rx_parity_err,
    input  logic             rx_frame_err,
    input  logic             rx_overrun,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic             cts_in,
    input  logic             dsr_in,
    input  logic             ri_in,
    input  logic             dcd_in,
    output logic             tx_push,
    output logic [7:0]       tx_byte,
    output logic             rx_pop,
    output logic [1:0]       word_len,
    output logic             two_stop,
    output logic             parity_en,
    output logic             parity_even,
    output logic             break_on,
    output logic [15:0]      divisor,
    output logic             fifo_en,
    output logic             enhanced_en,
    output logic             dtr,
    output logic             rts,
    output logic             irq
);

    localparam int NPIN = 4;

    logic [7:0]      lcr_r, scr_r, dll_r, dlm_r, efr_r, lsr_v;
    logic [3:0]      ier_r;
    logic [4:0]      mcr_r;
    logic            fifo_on_r, thr_wr, ier_thre_on;
    logic [1:0]      trig_sel_r;
    logic            line_err, data_ready, ovr_flag, thre_flag, any_delta;
    logic [NPIN-1:0] pin_sync, pin_delta;
    logic [5:0]      id_code;
    logic            bank2, lsr_read, msr_read, isr_read;

    // Read side-effect strobes
    always_comb begin
        bank2    = lcr_r[7];
        lsr_read = bus_rd && (bus_addr == OFS_LSTAT);
        msr_read = bus_rd && (bus_addr == OFS_MSTAT);
        isr_read = bus_rd && (bus_addr == OFS_FCTL) && !bank2;
        rx_pop   = bus_rd && (bus_addr == OFS_DATA) && !bank2 && data_ready;
    end

    serchan_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .lcr_q       (lcr_r),
        .ier_q       (ier_r),
        .mcr_q       (mcr_r),
        .scr_q       (scr_r),
        .dll_q       (dll_r),
        .dlm_q       (dlm_r),
        .efr_q       (efr_r),
        .fifo_on_q   (fifo_on_r),
        .trig_sel_q  (trig_sel_r),
        .thr_wr      (thr_wr),
        .ier_thre_on (ier_thre_on)
    );

    serchan_line_status #(.LVL_W(LVL_W)) u_lsr (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_level      (rx_level),
        .rx_parity_err (rx_parity_err),
        .rx_frame_err  (rx_frame_err),
        .rx_overrun    (rx_overrun),
        .tx_empty      (tx_empty),
        .lsr_read      (lsr_read),
        .lsr           (lsr_v),
        .line_err      (line_err),
        .data_ready    (data_ready),
        .ovr_q         (ovr_flag)
    );

    serchan_modem_status #(.NPIN(NPIN), .DELTA_MASK(4'b1011)) u_msr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      ({dcd_in, ri_in, dsr_in, cts_in}),
        .msr_read  (msr_read),
        .pin_q     (pin_sync),
        .delta_q   (pin_delta),
        .any_delta (any_delta)
    );

    serchan_int_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_int (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier         (ier_r),
        .line_err    (line_err),
        .data_ready  (data_ready),
        .rx_level    (rx_level),
        .fifo_on     (fifo_on_r),
        .trig_sel    (trig_sel_r),
        .rx_timeout  (rx_timeout),
        .tx_empty    (tx_empty),
        .thr_wr      (thr_wr),
        .ier_thre_on (ier_thre_on),
        .isr_read    (isr_read),
        .modem_delta (any_delta),
        .id_code     (id_code),
        .thre_q      (thre_flag),
        .irq         (irq)
    );

    // Read data multiplexer
    always_comb begin
        case (bus_addr)
            OFS_DATA:  bus_rdata = bank2 ? dll_r : rx_data;
            OFS_IEN:   bus_rdata = bank2 ? dlm_r : {4'b0, ier_r};
            OFS_FCTL:  bus_rdata = bank2 ? efr_r : {fifo_on_r, fifo_on_r, id_code};
            OFS_LCTL:  bus_rdata = lcr_r;
            OFS_MCTL:  bus_rdata = {3'b0, mcr_r};
            OFS_LSTAT: bus_rdata = lsr_v;
            OFS_MSTAT: bus_rdata = {pin_sync, pin_delta};
            default:   bus_rdata = scr_r;
        endcase
    end

    // Configuration outputs to the serializer, baud generator and pins
    always_comb begin
        tx_push     = thr_wr;
        tx_byte     = bus_wdata;
        word_len    = lcr_r[1:0];
        two_stop    = lcr_r[2];
        parity_en   = lcr_r[3];
        parity_even = lcr_r[4];
        break_on    = lcr_r[6];
        divisor     = {dlm_r, dll_r};
        fifo_en     = fifo_on_r;
        enhanced_en = efr_r[4];
        dtr         = mcr_r[0];
        rts         = mcr_r[1];
    end

endmodule

// File: rtl/serchan_regs_checker.sv
// Temporal checks on the serial channel register unit, bound to the top.
module serchan_regs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        rx_overrun,
    input logic        tx_empty,
    input logic        irq,
    input logic        break_on,
    input logic [15:0] divisor,
    input logic [7:0]  lcr_q,
    input logic [3:0]  ier_q,
    input logic        ovr_q,
    input logic        thre_q,
    input logic [3:0]  pins_now,
    input logic [3:0]  pin_q,
    input logic [3:0]  delta_q
);

    // Line-control write reaches the break output next cycle
    assert_break_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 3'd3 |=> break_on == $past(bus_wdata[6]));

    // Bank-2 write to offset 0 lands in the divisor low byte
    assert_divisor_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 3'd0 && lcr_q[7] |=> divisor[7:0] == $past(bus_wdata));

    // Line-status read without a new overrun clears the flag
    assert_ovr_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 3'd5 && !rx_overrun |=> !ovr_q);

    // Modem-status read with steady pins leaves no change flag
    assert_msr_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 3'd6 && pins_now == pin_q |=> delta_q == 4'b0);

    // Idle interrupt status reads as the none code
    assert_none_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 3'd2 && !lcr_q[7] && !irq |-> bus_rdata[5:0] == 6'h01);

    // A rising transmitter-empty level leaves the condition pending
    assert_thre_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |=> thre_q);

    // With every source masked no interrupt is raised
    assert_masked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ier_q == 4'h0 |-> !irq);

endmodule

bind serchan_regs serchan_regs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_overrun (rx_overrun),
    .tx_empty   (tx_empty),
    .irq        (irq),
    .break_on   (break_on),
    .divisor    (divisor),
    .lcr_q      (lcr_r),
    .ier_q      (ier_r),
    .ovr_q      (ovr_flag),
    .thre_q     (thre_flag),
    .pins_now   ({dcd_in, ri_in, dsr_in, cts_in}),
    .pin_q      (pin_sync),
    .delta_q    (pin_delta)
);

// File: tb/serchan_regs_test.sv
// Bench for serchan_regs: directed phases per requirement, then random
// traffic, with a behavioural model compared on every clock.
module serchan_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] rx_level = '0;
    logic [7:0] rx_data = '0;
    logic       rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_overrun = 1'b0;
    logic       rx_timeout = 1'b0, tx_empty = 1'b1;
    logic       cts_in = 1'b0, dsr_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
    logic       tx_push, rx_pop, two_stop, parity_en, parity_even, break_on;
    logic       fifo_en, enhanced_en, dtr, rts, irq;
    logic [7:0] tx_byte;
    logic [1:0] word_len;
    logic [15:0] divisor;

    int n_chk = 0, n_fail = 0;
    int push_cnt = 0, pop_cnt = 0;
    logic [7:0] last_push = '0;
    bit done = 0;

    always #5 clk = ~clk;

    serchan_regs uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp_v, $time);
        end
    endtask

    // ---------------- behavioural model ----------------
    logic [7:0] m_lcr = 0, m_ier = 0, m_mcr = 0, m_scr = 0, m_dll = 0, m_dlm = 0, m_efr = 0, m_fcr = 0;
    bit m_ovr = 0, m_thre = 0, m_txq = 1;
    bit m_q[4], m_d[4];

    function automatic int m_trig();
        case (m_fcr[7:6])
            2'd0: return 16;
            2'd1: return 32;
            2'd2: return 64;
            default: return 112;
        endcase
    endfunction

    function automatic int m_id();
        bit dr, lerr, avail, anyd;
        dr    = rx_level != 0;
        lerr  = m_ovr || (dr && (rx_parity_err || rx_frame_err));
        avail = m_fcr[0] ? (int'(rx_level) >= m_trig()) : dr;
        anyd  = m_d[0] || m_d[1] || m_d[3];
        if (m_ier[2] && lerr) return 6;
        if (m_ier[0] && avail) return 4;
        if (m_ier[0] && rx_timeout && dr) return 12;
        if (m_ier[1] && m_thre) return 2;
        if (m_ier[3] && anyd) return 0;
        return 1;
    endfunction

    function automatic logic [7:0] m_rdata();
        bit dr, pe, fe;
        dr = rx_level != 0;
        pe = dr && rx_parity_err;
        fe = dr && rx_frame_err;
        case (bus_addr)
            3'd0: return m_lcr[7] ? m_dll : rx_data;
            3'd1: return m_lcr[7] ? m_dlm : (m_ier & 8'h0F);
            3'd2: return m_lcr[7] ? m_efr : (8'(m_id()) | (m_fcr[0] ? 8'hC0 : 8'h00));
            3'd3: return m_lcr;
            3'd4: return m_mcr & 8'h1F;
            3'd5: return {pe || fe, 1'b0, tx_empty, 1'b0, fe, pe, m_ovr, dr};
            3'd6: return {m_q[3], m_q[2], m_q[1], m_q[0], m_d[3], 1'b0, m_d[1], m_d[0]};
            default: return m_scr;
        endcase
    endfunction

    always @(posedge clk) begin
        int id;
        bit dlab, pins[4];
        id   = m_id();
        dlab = m_lcr[7];
        pins[0] = cts_in; pins[1] = dsr_in; pins[2] = ri_in; pins[3] = dcd_in;
        if (!rst_n) begin
            m_lcr = 0; m_ier = 0; m_mcr = 0; m_scr = 0; m_dll = 0; m_dlm = 0; m_efr = 0; m_fcr = 0;
            m_ovr = 0; m_thre = 0;
            for (int i = 0; i < 4; i++) begin m_q[i] = 0; m_d[i] = 0; end
        end else begin
            if ((tx_empty && !m_txq) ||
                (bus_wr && bus_addr == 1 && !dlab && bus_wdata[1] && !m_ier[1] && tx_empty))
                m_thre = 1;
            else if ((bus_wr && bus_addr == 0 && !dlab) || (bus_rd && bus_addr == 2 && !dlab && id == 2))
                m_thre = 0;
            if (rx_overrun) m_ovr = 1;
            else if (bus_rd && bus_addr == 5) m_ovr = 0;
            for (int i = 0; i < 4; i++) begin
                if (i != 2 && pins[i] != m_q[i]) m_d[i] = 1;
                else if (bus_rd && bus_addr == 6) m_d[i] = 0;
                m_q[i] = pins[i];
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: if (dlab) m_dll = bus_wdata;
                    3'd1: if (dlab) m_dlm = bus_wdata; else m_ier = bus_wdata & 8'h0F;
                    3'd2: if (dlab) m_efr = bus_wdata; else m_fcr = bus_wdata & 8'hC1;
                    3'd3: m_lcr = bus_wdata;
                    3'd4: m_mcr = bus_wdata & 8'h1F;
                    3'd7: m_scr = bus_wdata;
                    default: ;
                endcase
            end
        end
        m_txq = tx_empty;
        if (tx_push) begin push_cnt++; last_push = tx_byte; end
        if (rx_pop) pop_cnt++;
    end

    // Every-clock comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t;
            bit dl;
            dl = m_lcr[7];
            case (bus_addr)
                3'd0: t = dl ? "R3" : "R4";
                3'd1: t = dl ? "R3" : "R12";
                3'd2: t = dl ? "R3" : "R10";
                3'd3: t = "R2";
                3'd4: t = "R5";
                3'd5: t = "R7";
                3'd6: t = "R9";
                default: t = "R13";
            endcase
            chk(bus_rdata == m_rdata(), t, bus_rdata, m_rdata());
            chk(irq == (m_id() != 1), "R12 irq", irq, m_id() != 1);
            chk({word_len, two_stop, parity_en, parity_even, break_on} ==
                {m_lcr[1:0], m_lcr[2], m_lcr[3], m_lcr[4], m_lcr[6]}, "R2 fmt",
                {word_len, two_stop, parity_en, parity_even, break_on},
                {m_lcr[1:0], m_lcr[2], m_lcr[3], m_lcr[4], m_lcr[6]});
            chk(divisor == {m_dlm, m_dll} && enhanced_en == m_efr[4], "R3 div", divisor, {m_dlm, m_dll});
            chk(dtr == m_mcr[0] && rts == m_mcr[1], "R5 pins", {dtr, rts}, {m_mcr[0], m_mcr[1]});
            chk(fifo_en == m_fcr[0], "R6 fifo_en", fifo_en, m_fcr[0]);
            chk(tx_push == (bus_wr && bus_addr == 0 && !dl), "R4 push", tx_push, bus_wr && bus_addr == 0 && !dl);
            chk(rx_pop == (bus_rd && bus_addr == 0 && !dl && rx_level != 0), "R4 pop", rx_pop,
                bus_rd && bus_addr == 0 && !dl && rx_level != 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp_v, input string tag);
        @(posedge clk); #2;
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        chk(bus_rdata == exp_v, tag, bus_rdata, exp_v);
        @(posedge clk); #2;
        bus_rd = 0;
    endtask

    task automatic rdn(input logic [2:0] a);
        @(posedge clk); #2;
        bus_rd = 1; bus_addr = a;
        @(posedge clk); #2;
        bus_rd = 0;
    endtask

    task automatic settle();
        @(posedge clk); #2;
        @(negedge clk);
    endtask

    task automatic lvl_irq(input int n, input bit exp_v, input string tag);
        @(posedge clk); #2;
        rx_level = 8'(n);
        @(negedge clk);
        chk(irq == exp_v, tag, irq, exp_v);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 0 && dtr == 0 && rts == 0, "R1 outputs", {irq, dtr, rts}, 0);
        chk(divisor == 0 && enhanced_en == 0, "R1 divisor", divisor, 0);
        rd(3, 8'h00, "R1 lcr");
        rd(1, 8'h00, "R1 ier");
        rd(4, 8'h00, "R1 mcr");
        rd(7, 8'h00, "R1 scr");
        rd(2, 8'h01, "R1 isr");
        rd(5, 8'h20, "R1 lsr");

        // R2 line format
        wr(3, 8'h5F); settle();
        chk(word_len == 3 && two_stop && parity_en && parity_even && break_on, "R2 fields",
            {word_len, two_stop, parity_en, parity_even, break_on}, 7'h7F);
        rd(3, 8'h5F, "R2 readback");
        wr(3, 8'h01); settle();
        chk(word_len == 1 && !two_stop && !parity_en && !break_on, "R2 5..8 bits", word_len, 1);

        // R3 second bank
        wr(3, 8'h83);
        wr(0, 8'h22); wr(1, 8'h01); wr(2, 8'h10); settle();
        chk(divisor == 16'h0122, "R3 divisor", divisor, 16'h0122);
        chk(enhanced_en == 1, "R3 enhanced", enhanced_en, 1);
        chk(push_cnt == 0, "R3 no push", push_cnt, 0);
        rd(0, 8'h22, "R3 dll"); rd(1, 8'h01, "R3 dlm"); rd(2, 8'h10, "R3 efr");
        wr(3, 8'h03);
        rd(1, 8'h00, "R3 ier untouched");
        rd(2, 8'h01, "R3 fcr untouched");

        // R4 holding register
        wr(0, 8'h3C);
        chk(push_cnt == 1 && last_push == 8'h3C, "R4 push byte", last_push, 8'h3C);
        rx_data = 8'hA5;
        rd(0, 8'hA5, "R4 empty read");
        chk(pop_cnt == 0, "R4 no pop when empty", pop_cnt, 0);
        rx_level = 3;
        rd(0, 8'hA5, "R4 rx read");
        chk(pop_cnt == 1, "R4 pop", pop_cnt, 1);
        rx_level = 0;

        // R5 modem control
        wr(4, 8'h03); settle();
        chk(dtr && rts, "R5 both", {dtr, rts}, 3);
        wr(4, 8'h02); settle();
        chk(!dtr && rts, "R5 rts only", {dtr, rts}, 1);

        // R6 trigger levels
        wr(1, 8'h01);
        wr(2, 8'hC1);
        lvl_irq(111, 0, "R6 112-1");
        lvl_irq(112, 1, "R6 112");
        rd(2, 8'hC4, "R6 isr data");
        wr(2, 8'h41); lvl_irq(31, 0, "R6 32-1"); lvl_irq(32, 1, "R6 32");
        wr(2, 8'h81); lvl_irq(63, 0, "R6 64-1"); lvl_irq(64, 1, "R6 64");
        wr(2, 8'h01); lvl_irq(15, 0, "R6 16-1"); lvl_irq(16, 1, "R6 16");
        wr(2, 8'h00); lvl_irq(1, 1, "R6 no fifo 1"); lvl_irq(0, 0, "R6 no fifo 0");

        // R7 line status
        tx_empty = 1; rx_level = 1; rx_parity_err = 1;
        rd(5, 8'hA5, "R7 parity");
        rx_parity_err = 0; rx_frame_err = 1;
        rd(5, 8'hA9, "R7 framing");
        rx_frame_err = 0; tx_empty = 0;
        rd(5, 8'h01, "R7 clean");

        // R8 overrun
        @(posedge clk); #2 rx_overrun = 1;
        @(posedge clk); #2 rx_overrun = 0;
        rd(5, 8'h03, "R8 set");
        rd(5, 8'h01, "R8 cleared");

        // R9 modem status
        rdn(6);
        cts_in = 1; settle();
        rd(6, 8'h11, "R9 cts delta");
        rd(6, 8'h10, "R9 cleared");
        ri_in = 1; settle();
        rd(6, 8'h50, "R9 ri no delta");
        dcd_in = 1; settle();
        rd(6, 8'hD8, "R9 dcd delta");
        rd(6, 8'hD0, "R9 dcd cleared");

        // R10 priority stack
        rx_level = 0; tx_empty = 1; rdn(5); rdn(6);
        wr(1, 8'h0F);
        rx_level = 1; rx_parity_err = 1;
        rd(2, 8'h06, "R10 line first");
        rx_parity_err = 0;
        rd(2, 8'h04, "R10 data second");
        wr(2, 8'h01); rx_level = 5; rx_timeout = 1;
        rd(2, 8'hCC, "R10 timeout");
        rx_timeout = 0; rx_level = 0; wr(2, 8'h00);
        tx_empty = 0; settle(); tx_empty = 1; dsr_in = 1; settle();
        rd(2, 8'h02, "R10 thre");
        rd(2, 8'h00, "R10 modem last");
        rdn(6);
        rd(2, 8'h01, "R10 none");
        chk(irq == 0, "R10 irq low", irq, 0);

        // R11 transmitter-empty condition
        wr(1, 8'h00); wr(1, 8'h02);
        rd(2, 8'h02, "R11 enable sets");
        rd(2, 8'h01, "R11 read clears");
        tx_empty = 0; settle(); tx_empty = 1; settle();
        wr(0, 8'h11);
        rd(2, 8'h01, "R11 write clears");
        tx_empty = 0; settle(); tx_empty = 1; settle();
        chk(irq == 1, "R11 rise sets", irq, 1);

        // R12 masking
        wr(1, 8'h00); settle();
        chk(irq == 0, "R12 masked", irq, 0);

        // R13 scratch
        wr(7, 8'h5A);
        rd(7, 8'h5A, "R13 scratch");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #2;
            bus_addr      = 3'($urandom_range(0, 7));
            bus_wr        = ($urandom_range(0, 3) == 0);
            bus_rd        = !bus_wr && ($urandom_range(0, 2) == 0);
            bus_wdata     = 8'($urandom);
            rx_level      = 8'($urandom_range(0, 128));
            rx_data       = 8'($urandom);
            rx_parity_err = ($urandom_range(0, 7) == 0);
            rx_frame_err  = ($urandom_range(0, 7) == 0);
            rx_overrun    = ($urandom_range(0, 15) == 0);
            rx_timeout    = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) tx_empty = ~tx_empty;
            if ($urandom_range(0, 9) == 0) cts_in = ~cts_in;
            if ($urandom_range(0, 9) == 0) dsr_in = ~dsr_in;
            if ($urandom_range(0, 9) == 0) ri_in  = ~ri_in;
            if ($urandom_range(0, 9) == 0) dcd_in = ~dcd_in;
        end
        @(posedge clk); #2;
        bus_wr = 0; bus_rd = 0;
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule